// File: doc/BRIEF.md
# SPI Byte Master

This block is a serial peripheral interface master for one slave. In each transfer it sends one byte and receives one byte. A single 16-state phase counter, clocked by the system clock, sets all of its timing. From that count the block derives the serial clock, the points at which the shift registers move, and a one-cycle completion flag.

The host side has three parts:
- A parallel load port, qualified by `load_valid`.
- A parallel receive port. It is driven only while the completion flag is high.
- An `enable` input that starts and stops the bus.

The load port has no back-pressure. A load presented in any cycle is accepted on that clock edge, so the port behaves as if ready were always high. The host sends bytes back to back by presenting the next byte during the last phase of the current transfer.

The bus idles with the clock high. The slave samples on the falling edge of the serial clock, and MOSI changes on the rising edge (CPOL=1, CPHA=0). Bytes go out most significant bit first.

Top module: `spi_byte_master`

## Requirements
- R1: While `rst_n` is low, `spi_cs_n` and `spi_sclk` are high and `rx_valid` is low. Reset clears both shift registers, so `spi_mosi` reads 0 after reset.
- R2: While `enable` is low, `spi_cs_n` and `spi_sclk` are high and the phase count returns to 0.
- R3: While enabled, the phase count advances once per system clock. `spi_sclk` is high in even phases (phase 0 included) and low in odd phases, so one transfer spans 16 system clocks.
- R4: `spi_mosi` always equals bit 7 of the transmit register. That register shifts left by one bit on each clock edge that ends an odd phase, so bytes leave MSB first. Loading 0xAA and shifting once leaves 0x54.
- R5: A `load_valid` high at a clock edge writes `load_data` into the transmit register, in any phase and whether enabled or not. On an edge that would also shift, the load wins.
- R6: On each edge that ends an odd phase, the receive register shifts left and takes `spi_miso` into bit 0.
- R7: `rx_valid` is high for exactly the one cycle after phase 15. In that cycle `rx_data` shows the eight bits just received. At all other times `rx_data` is not driven.
- R8: With `enable` held high, transfers follow each other with no gap. A byte loaded during phase 15 is sent in the next transfer.
- R9: Dropping `enable` in the middle of a transfer aborts it with no `rx_valid`. The next enable starts again at phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the bus while high |
| load_valid | input | 1 | Writes `load_data` into the transmit register |
| load_data | input | 8 | Byte to send |
| rx_data | output | 8 | Received byte; high impedance unless `rx_valid` |
| rx_valid | output | 1 | One-cycle completion flag |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs_n | output | 1 | Active-low slave select |

## Verification
The bench models the slave at the pins. That model returns a byte of its own on MISO and records what it samples on MOSI, so both directions are checked within every transfer.

- Directed bytes 0xAA and 0x59 check MSB-first order and the single-shift result.
- A load presented in an odd phase is chosen so that a shift winning over the load would be visible on MOSI two shifts later.
- A chained pair of transfers separates gap-free restart from a restart that waits on `enable`.
- An aborted transfer and a reset in the middle of a frame show that the phase count and the flag restart.
- Forty random byte pairs from a fixed seed cover general data patterns.

// File: rtl/spi_bs_pkg.sv
package spi_bs_pkg;
  // phase counter width; one transfer is 2**PHASE_W system clocks
  localparam int PHASE_W = 4;
  // two phases per bit
  localparam int WORD_W  = 2 ** (PHASE_W - 1);
endpackage

// File: rtl/spi_bs_phase.sv
module spi_bs_phase #(
  parameter int PW = spi_bs_pkg::PHASE_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic strobe,
  output logic done
);
  localparam logic [PW-1:0] LAST = '1;

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      done    <= 1'b0;
    end else if (!run) begin
      phase_q <= '0;
      done    <= 1'b0;
    end else begin
      phase_q <= phase_q + 1'b1;
      // flag set on the edge that ends the last phase
      done    <= (phase_q == LAST);
    end
  end

  // odd phases: clock low and shift point armed
  assign strobe = run & phase_q[0];
  assign sclk   = ~strobe;
endmodule

// File: rtl/spi_bs_shreg.sv
module spi_bs_shreg #(
  parameter int W        = spi_bs_pkg::WORD_W,
  parameter bit HAS_LOAD = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         ser_in,
  output logic [W-1:0] q
);
  generate
    if (HAS_LOAD) begin : g_load
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (load)  q <= load_val;
        else if (shift) q <= {q[W-2:0], ser_in};
      end
    end else begin : g_noload
      logic unused_load;
      assign unused_load = ^{load, load_val};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (shift) q <= {q[W-2:0], ser_in};
      end
    end
  endgenerate
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_bs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              load_valid,
  input  logic [WORD_W-1:0] load_data,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  logic              active;
  logic              stb;
  logic [WORD_W-1:0] tx_q;
  logic [WORD_W-1:0] rx_q;

  assign active = enable & rst_n;

  spi_bs_phase #(.PW(PHASE_W)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (active),
    .sclk   (spi_sclk),
    .strobe (stb),
    .done   (rx_valid)
  );

  spi_bs_shreg #(.W(WORD_W), .HAS_LOAD(1'b1)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_valid),
    .load_val (load_data),
    .shift    (stb),
    .ser_in   (1'b0),
    .q        (tx_q)
  );

  spi_bs_shreg #(.W(WORD_W), .HAS_LOAD(1'b0)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (1'b0),
    .load_val ('0),
    .shift    (stb),
    .ser_in   (spi_miso),
    .q        (rx_q)
  );

  assign spi_mosi = tx_q[WORD_W-1];
  assign spi_cs_n = ~active;
  assign rx_data  = rx_valid ? rx_q : {WORD_W{1'bz}};
endmodule

// File: rtl/spi_bs_chk.sv
module spi_bs_chk (
  input logic clk,
  input logic rst_n,
  input logic load_valid,
  input logic sclk,
  input logic mosi,
  input logic cs_n,
  input logic rx_valid
);
  // R1
  always_comb begin
    if (rst_n === 1'b0) begin
      reset_idle_chk: assert (cs_n && sclk && !rx_valid);
    end
  end

  // R2
  deselect_clock_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  // R3
  sclk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> (sclk != $past(sclk)));

  // R4
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclk) && !$past(load_valid)) |-> $stable(mosi));

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R7
  valid_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($past(!sclk) && $past(!cs_n)));
endmodule

bind spi_byte_master spi_bs_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_valid (load_valid),
  .sclk       (spi_sclk),
  .mosi       (spi_mosi),
  .cs_n       (spi_cs_n),
  .rx_valid   (rx_valid)
);

// File: tb/spi_byte_master_test.sv
`timescale 1ns/1ps
module spi_byte_master_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       load_valid = 1'b0;
  logic [7:0] load_data = '0;
  logic       spi_miso = 1'b0;
  wire  [7:0] rx_data;
  logic       rx_valid, spi_sclk, spi_mosi, spi_cs_n;

  int checks = 0;
  int fails  = 0;

  // slave model state
  logic [7:0] slave_next = '0;
  logic [7:0] s_tx = '0;
  logic [7:0] s_rx = '0;
  int         s_cnt = 0;
  logic       s_prev = 1'b1;

  always #10 clk = ~clk;

  spi_byte_master uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .load_valid(load_valid),
    .load_data(load_data), .rx_data(rx_data), .rx_valid(rx_valid),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // the slave samples MOSI on falling sclk and updates MISO on rising sclk
  task automatic slave_step();
    if (spi_cs_n) begin
      s_tx  = slave_next;
      s_cnt = 0;
      spi_miso = s_tx[7];
    end else begin
      if (s_prev && !spi_sclk) begin
        s_rx = {s_rx[6:0], spi_mosi};
        s_cnt++;
      end else if (!s_prev && spi_sclk) begin
        if (s_cnt == 8) begin
          s_tx  = slave_next;
          s_cnt = 0;
        end else begin
          s_tx = s_tx << 1;
        end
        spi_miso = s_tx[7];
      end
    end
    s_prev = spi_sclk;
  endtask

  task automatic tick();
    @(negedge clk);
    slave_step();
  endtask

  function automatic logic exp_sclk(input int ph);
    return (ph % 2) == 0;
  endfunction

  function automatic logic exp_mosi(input logic [7:0] b, input int ph);
    return b[7 - ph / 2];
  endfunction

  task automatic load_idle(input logic [7:0] mb, input logic [7:0] sb);
    enable = 1'b0;
    tick();
    load_valid = 1'b1;
    load_data  = mb;
    slave_next = sb;
    tick();
    load_valid = 1'b0;
    check("R2 cs_n while disabled", spi_cs_n, 1'b1);
  endtask

  // called with phase 0 visible; leaves phase 0 of the next transfer visible
  task automatic run_frame(input logic [7:0] mb, input logic [7:0] sb,
                           input bit chain, input logic [7:0] nb, input logic [7:0] nsb);
    enable = 1'b1;
    for (int i = 1; i <= 16; i++) begin
      tick();
      if (i < 16) check("R3 sclk phase", spi_sclk, exp_sclk(i));
      if (i < 16 && i % 2 == 0) check("R4 mosi bit", spi_mosi, exp_mosi(mb, i));
      if (i == 15) begin
        check("R7 valid low before end", rx_valid, 1'b0);
        if (chain) begin
          load_valid = 1'b1;
          load_data  = nb;
          slave_next = nsb;
        end
      end
      if (i == 16) begin
        load_valid = 1'b0;
        check("R7 valid at end", rx_valid, 1'b1);
        check("R6 received byte", rx_data, sb);
        check("R4 slave got byte", s_rx, mb);
        if (chain) check("R8 next byte on mosi", spi_mosi, nb[7]);
      end
    end
  endtask

  task automatic finish_idle();
    enable = 1'b0;
    tick();
    check("R7 valid one cycle", rx_valid, 1'b0);
    check("R2 cs_n after stop", spi_cs_n, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] mb, sb;
    mb = 8'($urandom(32'd20240));
    rst_n  = 1'b0;
    enable = 1'b1;
    tick();
    tick();
    check("R1 cs_n in reset", spi_cs_n, 1'b1);
    check("R1 sclk in reset", spi_sclk, 1'b1);
    check("R1 valid in reset", rx_valid, 1'b0);
    rst_n  = 1'b1;
    enable = 1'b0;
    tick();
    check("R1 mosi cleared", spi_mosi, 1'b0);
    check("R2 sclk idle", spi_sclk, 1'b1);

    // directed bytes
    load_idle(8'hAA, 8'h59);
    run_frame(8'hAA, 8'h59, 1'b0, 8'h00, 8'h00);
    finish_idle();

    // R5: a load in an odd phase wins over the shift
    load_idle(8'hAA, 8'h00);
    enable = 1'b1;
    for (int i = 1; i <= 8; i++) begin
      tick();
      if (i == 2) check("R4 0xAA one shift gives 0x54 msb", spi_mosi, 1'b0);
      if (i == 3) begin
        load_valid = 1'b1;
        load_data  = 8'hC3;
      end
      if (i == 4) begin
        load_valid = 1'b0;
        check("R5 loaded msb", spi_mosi, 1'b1);
      end
      if (i == 6) check("R5 load beat shift", spi_mosi, 1'b1);
      if (i == 8) check("R5 load beat shift", spi_mosi, 1'b0);
    end
    enable = 1'b0;
    tick();

    // R9: abort in the middle, then a full restart
    load_idle(8'h5A, 8'hE7);
    enable = 1'b1;
    repeat (5) tick();
    enable = 1'b0;
    tick();
    check("R9 cs_n after abort", spi_cs_n, 1'b1);
    check("R9 sclk after abort", spi_sclk, 1'b1);
    check("R9 no valid on abort", rx_valid, 1'b0);
    tick();
    check("R9 no valid on abort", rx_valid, 1'b0);
    run_frame(8'h5A << 2, 8'hE7, 1'b0, 8'h00, 8'h00);
    finish_idle();

    // R8: back to back transfers
    load_idle(8'h96, 8'h0F);
    run_frame(8'h96, 8'h0F, 1'b1, 8'h3C, 8'hF0);
    run_frame(8'h3C, 8'hF0, 1'b0, 8'h00, 8'h00);
    finish_idle();

    // random byte pairs
    for (int n = 0; n < 40; n++) begin
      mb = 8'($urandom);
      sb = 8'($urandom);
      load_idle(mb, sb);
      run_frame(mb, sb, 1'b0, 8'h00, 8'h00);
      finish_idle();
    end

    // R1: reset in the middle of a transfer
    load_idle(8'hFF, 8'hFF);
    enable = 1'b1;
    repeat (6) tick();
    rst_n = 1'b0;
    tick();
    check("R1 cs_n on mid reset", spi_cs_n, 1'b1);
    check("R1 sclk on mid reset", spi_sclk, 1'b1);
    check("R1 valid on mid reset", rx_valid, 1'b0);
    check("R1 tx cleared", spi_mosi, 1'b0);
    rst_n  = 1'b1;
    enable = 1'b0;
    tick();

    summary();
    $finish;
  end
endmodule